// File: doc/BRIEF.md
# Inter-Processor Doorbell Register Block

This block is the interrupt endpoint of one agent in a system of eleven peer agents. Software on the owning agent reaches it through a 32-bit single-cycle register port. Through that port it can ring doorbells toward its peers, observe what the peers currently show, take and acknowledge incoming requests, and choose which sources may raise its interrupt line.

The eleven sources occupy fixed positions in every 32-bit register word. Bit 0 is the application cluster, bits 8 and 9 are two real-time cores, bits 16 to 19 are four management channels, and bits 24 to 27 are four fabric channels. On the pin side, each source is one lane of an 11-bit vector, numbered in rising bit order. Lane 0 is bit 0, lanes 1 and 2 are bits 8 and 9, lanes 3 to 6 are bits 16 to 19, and lanes 7 to 10 are bits 24 to 27.

Incoming request levels set sticky pending bits. Each pending bit is also mirrored out to the peers. Software acknowledges a request with a write-1-to-clear. The mask cannot be written directly: it changes only through a separate unmask register and a separate mask register. Register reads return data one cycle after the read strobe.

Top module: `xdb_endpoint`

## Requirements
- R1: After a synchronous reset, pending is 0, the mask reads 0x0F0F0301, `irq_o`, `trig_o` and `mirror_o` are all zero, and the doorbell register (0x00) reads 0.
- R2: A write to offset 0x00 drives `trig_o` high, for exactly the cycle after the write, on each lane whose bit was 1. Lanes whose bits were 0 stay low, as do lanes for unimplemented bits. The register always reads 0.
- R3: A `req_i` lane that is high at a clock edge sets its pending bit. The bit stays set after `req_i` falls. The pending bits read at offset 0x10 and drive `mirror_o`.
- R4: Writing 1 to a pending bit at 0x10 clears it. Writing 0 leaves it unchanged.
- R5: If a request and a clearing write hit the same lane in the same cycle, the bit stays set.
- R6: The mask register at 0x14 ignores writes.
- R7: Writing 1s to 0x18 clears the matching mask bits, and writing 1s to 0x1C sets them. Both registers read 0.
- R8: `irq_o` is high exactly when some pending bit is set while its mask bit is clear. It reflects each pending, unmask or mask change at the same edge as that change.
- R9: Offset 0x04 returns the level of `obs_i`, registered once, in the implemented bit positions. Writes to it have no effect.
- R10: Reads of unmapped or unaligned offsets return 0, and writes to them change nothing. Unimplemented bit positions read 0 in every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe; `bus_rdata` is valid the next cycle |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| req_i | input | NUM_SRC | Incoming request levels, one lane per peer |
| obs_i | input | NUM_SRC | Peer observation levels |
| trig_o | output | NUM_SRC | One-cycle doorbell pulses toward peers |
| mirror_o | output | NUM_SRC | Copy of the pending bits for peers |
| irq_o | output | 1 | Level interrupt to the owning agent |

## Verification
On every cycle, the embedded properties check the following. Doorbell pulses last one cycle unless they are re-fired. Pending bits never drop without a matching clear. A request always leaves its bit set, even under a clear. Unmask and mask writes take effect, and the mask otherwise holds. The interrupt equals the masked pending OR, and an unmapped read returns zero. Only the bench's scenarios can show the absolute register encoding in the 32-bit words, the reset values, and the read-as-zero of the write-only registers. They also show that a write to a read-only register is ignored, and the one-cycle latency of the observation path.

// File: rtl/xdb_pkg.sv
package xdb_pkg;

  localparam int REG_W = 32;

  localparam logic [31:0] OFS_DOORBELL = 32'h00;
  localparam logic [31:0] OFS_OBSERVE  = 32'h04;
  localparam logic [31:0] OFS_PENDING  = 32'h10;
  localparam logic [31:0] OFS_MASK     = 32'h14;
  localparam logic [31:0] OFS_UNMASK   = 32'h18;
  localparam logic [31:0] OFS_SETMASK  = 32'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DOORBELL,
    SEL_OBSERVE,
    SEL_PENDING,
    SEL_MASK,
    SEL_UNMASK,
    SEL_SETMASK
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [31:0] ofs);
    case (ofs)
      OFS_DOORBELL: return SEL_DOORBELL;
      OFS_OBSERVE:  return SEL_OBSERVE;
      OFS_PENDING:  return SEL_PENDING;
      OFS_MASK:     return SEL_MASK;
      OFS_UNMASK:   return SEL_UNMASK;
      OFS_SETMASK:  return SEL_SETMASK;
      default:      return SEL_NONE;
    endcase
  endfunction

  // Pack the implemented bits of a register word into consecutive lanes.
  function automatic logic [31:0] gather(input logic [31:0] vm, input logic [31:0] word);
    logic [31:0] res;
    int n;
    res = '0;
    n = 0;
    for (int b = 0; b < 32; b++) begin
      if (vm[b]) begin
        res[n] = word[b];
        n++;
      end
    end
    return res;
  endfunction

  // Spread consecutive lanes back onto the implemented bit positions.
  function automatic logic [31:0] spread(input logic [31:0] vm, input logic [31:0] lanes);
    logic [31:0] res;
    int n;
    res = '0;
    n = 0;
    for (int b = 0; b < 32; b++) begin
      if (vm[b]) begin
        res[b] = lanes[n];
        n++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/xdb_trig.sv
module xdb_trig #(
  parameter int NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] fire_i,
  output logic [NUM_SRC-1:0] trig_o
);

  logic [NUM_SRC-1:0] pulse_q;

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= '0;
    else     pulse_q <= fire_i;
  end

  assign trig_o = pulse_q;

  // A doorbell lane that is not re-fired falls after one cycle.
  assert_pulse_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    (pulse_q != '0) |=> ((pulse_q & ~$past(fire_i)) == '0));

endmodule

// File: rtl/xdb_status.sv
module xdb_status #(
  parameter int NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] pend_nxt_o
);

  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] pend_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    // A request outranks an acknowledge on the same lane.
    assign pend_d[i] = req_i[i] | (pend_q[i] & ~clr_i[i]);

    always_ff @(posedge clk) begin
      if (rst) pend_q[i] <= 1'b0;
      else     pend_q[i] <= pend_d[i];
    end
  end

  assign pend_o     = pend_q;
  assign pend_nxt_o = pend_d;

  assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i)));

  assert_request_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (req_i != '0) |=> ((pend_q & $past(req_i)) == $past(req_i)));

  assert_w1c_R4: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~req_i) != '0) |=> ((pend_q & $past(clr_i & ~req_i)) == '0));

endmodule

// File: rtl/xdb_mask.sv
module xdb_mask #(
  parameter int NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] unmask_i,
  input  logic [NUM_SRC-1:0] setmask_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] mask_nxt_o
);

  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] mask_d;

  always_comb begin
    mask_d = (mask_q & ~unmask_i) | setmask_i;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else     mask_q <= mask_d;
  end

  assign mask_o     = mask_q;
  assign mask_nxt_o = mask_d;

  assert_unmask_R7: assert property (@(posedge clk) disable iff (rst)
    ((unmask_i != '0) && (setmask_i == '0)) |=> ((mask_q & $past(unmask_i)) == '0));

  assert_setmask_R7: assert property (@(posedge clk) disable iff (rst)
    (setmask_i != '0) |=> ((mask_q & $past(setmask_i)) == $past(setmask_i)));

  assert_mask_holds_R6: assert property (@(posedge clk) disable iff (rst)
    ((unmask_i == '0) && (setmask_i == '0)) |=> $stable(mask_q));

endmodule

// File: rtl/xdb_endpoint.sv
module xdb_endpoint #(
  parameter int          ADDR_W     = 8,
  parameter int          NUM_SRC    = 11,
  parameter logic [31:0] VALID_MASK = 32'h0F0F0301
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr_en,
  input  logic               bus_rd_en,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] obs_i,
  output logic [NUM_SRC-1:0] trig_o,
  output logic [NUM_SRC-1:0] mirror_o,
  output logic               irq_o
);
  import xdb_pkg::*;

  localparam int PAD_W = REG_W - NUM_SRC;

  reg_sel_e           sel;
  logic [31:0]        wlanes_full;
  logic [NUM_SRC-1:0] wlanes;
  logic [NUM_SRC-1:0] fire, clr, unmask, setmask;
  logic [NUM_SRC-1:0] pend, pend_nxt, mask, mask_nxt;
  logic [NUM_SRC-1:0] obs_q;
  logic               irq_q;
  logic [31:0]        rdata_q;
  logic [31:0]        rd_val;

  assign sel         = decode(32'(bus_addr));
  assign wlanes_full = gather(VALID_MASK, bus_wdata);
  assign wlanes      = wlanes_full[NUM_SRC-1:0];

  assign fire    = (bus_wr_en && sel == SEL_DOORBELL) ? wlanes : '0;
  assign clr     = (bus_wr_en && sel == SEL_PENDING)  ? wlanes : '0;
  assign unmask  = (bus_wr_en && sel == SEL_UNMASK)   ? wlanes : '0;
  assign setmask = (bus_wr_en && sel == SEL_SETMASK)  ? wlanes : '0;

  xdb_trig #(.NUM_SRC(NUM_SRC)) u_trig (
    .clk    (clk),
    .rst    (rst),
    .fire_i (fire),
    .trig_o (trig_o)
  );

  xdb_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .clr_i      (clr),
    .pend_o     (pend),
    .pend_nxt_o (pend_nxt)
  );

  xdb_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk        (clk),
    .rst        (rst),
    .unmask_i   (unmask),
    .setmask_i  (setmask),
    .mask_o     (mask),
    .mask_nxt_o (mask_nxt)
  );

  always_comb begin
    case (sel)
      SEL_OBSERVE: rd_val = spread(VALID_MASK, {{PAD_W{1'b0}}, obs_q});
      SEL_PENDING: rd_val = spread(VALID_MASK, {{PAD_W{1'b0}}, pend});
      SEL_MASK:    rd_val = spread(VALID_MASK, {{PAD_W{1'b0}}, mask});
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      obs_q   <= '0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      obs_q <= obs_i;
      irq_q <= |(pend_nxt & ~mask_nxt);
      if (bus_rd_en) rdata_q <= rd_val;
    end
  end

  assign bus_rdata = rdata_q;
  assign mirror_o  = pend;
  assign irq_o     = irq_q;

  assert_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (irq_q == |(pend & ~mask)));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && sel == SEL_NONE) |=> (rdata_q == '0));

  assert_obs_follows_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (obs_q == $past(obs_i)));

endmodule

// File: tb/xdb_endpoint_bench.sv
`timescale 1ns/1ps
module xdb_endpoint_bench;

  localparam int          N  = 11;
  localparam logic [31:0] VM = 32'h0F0F0301;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  req = '0, obs = '0;
  logic [N-1:0]  trig, mirror;
  logic          irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xdb_endpoint u_xdb_endpoint (
    .clk(clk), .rst(rst), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .req_i(req), .obs_i(obs), .trig_o(trig), .mirror_o(mirror), .irq_o(irq)
  );

  // {is_write, req number, offset, write data, expected read}
  localparam int NV = 23;
  localparam logic [76:0] TBL [NV] = '{
    {1'b0, 4'd1,  8'h10, 32'h0,        32'h00000000},
    {1'b0, 4'd1,  8'h14, 32'h0,        32'h0F0F0301},
    {1'b0, 4'd2,  8'h00, 32'h0,        32'h00000000},
    {1'b1, 4'd6,  8'h14, 32'h00000000, 32'h0},
    {1'b0, 4'd6,  8'h14, 32'h0,        32'h0F0F0301},
    {1'b1, 4'd7,  8'h18, 32'h00000301, 32'h0},
    {1'b0, 4'd7,  8'h14, 32'h0,        32'h0F0F0000},
    {1'b0, 4'd7,  8'h18, 32'h0,        32'h00000000},
    {1'b0, 4'd7,  8'h1C, 32'h0,        32'h00000000},
    {1'b1, 4'd7,  8'h1C, 32'h00000100, 32'h0},
    {1'b0, 4'd7,  8'h14, 32'h0,        32'h0F0F0100},
    {1'b1, 4'd10, 8'h18, 32'hFFFFFFFF, 32'h0},
    {1'b0, 4'd10, 8'h14, 32'h0,        32'h00000000},
    {1'b1, 4'd7,  8'h1C, 32'hFFFFFFFF, 32'h0},
    {1'b0, 4'd7,  8'h14, 32'h0,        32'h0F0F0301},
    {1'b1, 4'd10, 8'h20, 32'hFFFFFFFF, 32'h0},
    {1'b0, 4'd10, 8'h20, 32'h0,        32'h00000000},
    {1'b0, 4'd10, 8'h08, 32'h0,        32'h00000000},
    {1'b0, 4'd10, 8'h0C, 32'h0,        32'h00000000},
    {1'b0, 4'd10, 8'h14, 32'h0,        32'h0F0F0301},
    {1'b1, 4'd9,  8'h04, 32'hFFFFFFFF, 32'h0},
    {1'b0, 4'd9,  8'h04, 32'h0,        32'h00000000},
    {1'b0, 4'd10, 8'h1D, 32'h0,        32'h00000000}
  };

  function automatic logic [31:0] expand(input logic [N-1:0] lanes);
    logic [31:0] r = '0;
    int k = 0;
    for (int b = 0; b < 32; b++)
      if (VM[b]) begin r[b] = lanes[k]; k++; end
    return r;
  endfunction

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state at the pins
    check("R1 irq",    {31'b0, irq}, 32'h0);
    check("R1 trig",   32'(trig),    32'h0);
    check("R1 mirror", 32'(mirror),  32'h0);
    check("R1 rdata",  rdata,        32'h0);

    // Register-level vector table
    for (int i = 0; i < NV; i++) begin
      logic [76:0] e = TBL[i];
      if (e[76]) wr(e[71:64], e[63:32]);
      else begin
        rd(e[71:64], v);
        check($sformatf("R%0d vec%0d", e[75:72], i), v, e[31:0]);
      end
    end

    // R2 doorbell pulses
    wr(8'h00, 32'hFFFFFFFF);
    check("R2 all lanes pulse", 32'(trig), 32'h7FF);
    @(negedge clk);
    check("R2 pulse ends", 32'(trig), 32'h0);
    wr(8'h00, 32'h01000001);
    check("R2 lanes 0 and 7", 32'(trig), 32'h081);
    @(negedge clk);
    check("R2 pulse ends 2", 32'(trig), 32'h0);
    wr(8'h00, 32'hF0F0FCFE);
    check("R2 unimplemented bits", 32'(trig), 32'h0);
    rd(8'h00, v);
    check("R2 reads zero", v, 32'h0);

    // R3 sticky pending, R8 masked
    @(negedge clk); req = 11'b000_0000_1000;
    @(negedge clk); req = '0;
    repeat (3) @(negedge clk);
    check("R3 mirror", 32'(mirror), 32'h008);
    rd(8'h10, v);
    check("R3 pending read", v, expand(11'b000_0000_1000));
    check("R8 masked no irq", {31'b0, irq}, 32'h0);

    // R8 unmask / mask / clear
    wr(8'h18, 32'h00010000);
    check("R8 unmask raises irq", {31'b0, irq}, 32'h1);
    wr(8'h1C, 32'h00010000);
    check("R8 mask drops irq", {31'b0, irq}, 32'h0);
    wr(8'h18, 32'h00010000);
    check("R8 irq again", {31'b0, irq}, 32'h1);

    // R4 write-0 keeps, write-1 clears
    wr(8'h10, 32'hFEFEFFFF);
    check("R4 zero keeps", 32'(mirror), 32'h008);
    wr(8'h10, 32'h00010000);
    check("R4 one clears", 32'(mirror), 32'h000);
    check("R8 clear drops irq", {31'b0, irq}, 32'h0);

    // R5 request beats same-cycle clear
    @(negedge clk);
    req = 11'b000_0000_1000; wr_en = 1'b1; addr = 8'h10; wdata = 32'h00010000;
    @(negedge clk);
    req = '0; wr_en = 1'b0; wdata = '0;
    check("R5 set wins", 32'(mirror), 32'h008);
    check("R5 irq", {31'b0, irq}, 32'h1);
    wr(8'h10, 32'h00010000);
    check("R5 later clear", 32'(mirror), 32'h000);

    // R9 observation follows input
    @(negedge clk); obs = 11'b101_0010_0101;
    rd(8'h04, v);
    check("R9 observe", v, expand(11'b101_0010_0101));
    @(negedge clk); obs = 11'b010_1101_1010;
    rd(8'h04, v);
    check("R9 observe 2", v, expand(11'b010_1101_1010));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule